// File: doc/BRIEF.md
# Command-Pointer Two-Wire Register Slave

This block is the bus-facing front end of a small port expander. It listens on a two-wire serial bus (I2C-compatible), oversampling SCL and SDA on the system clock through a spike filter. It recognises START, repeated START and STOP conditions and answers only to one fixed 7-bit address. It acknowledges and pulls SDA low through a single active-high enable; there is no push-pull driver. Transfers reach a four-entry register bank that lives in the neighbouring port core. The slave drives a register select, a write strobe with its byte, and a read strobe, and it takes the selected register's value back on a read-data input.

Register selection uses a pointer loaded by the command byte. This is the first byte after the address in a write transfer. The pointer never advances by itself. Every data byte written in a transfer lands in the same register, and every byte read comes from it. The pointer also survives STOP, so a later transfer that only reads returns the register chosen last. Each read byte is fetched fresh at the moment its transmission begins. A long read of the input register therefore follows the live port state.

Top module: `sreg_i2c_slave`

## Requirements
- R1: Address byte `1001001` in bits 7..1 with R/W in bit 0 (0 = write, 1 = read) is acknowledged by pulling SDA low for the ninth clock. Any other address gets no acknowledge, and the rest of that transfer causes no strobe.
- R2: In a write transfer, the byte after the address is a command byte. It is always acknowledged, even when its value exceeds 3. The register select becomes its low 2 bits (0 input, 1 output, 2 polarity, 3 direction).
- R3: Each written data byte is acknowledged. It is presented on `reg_wdata` with a one-cycle `reg_wr` pulse after the SCL fall that closes its acknowledge bit. All data bytes of one transfer go to the same register select.
- R4: In a read transfer, each byte is captured from `reg_rdata` with a one-cycle `reg_rd` pulse, then sent MSB first. The first byte is captured at the SCL fall closing the address acknowledge. Each later byte is captured at the SCL fall closing the master's ACK, so the value reflects the register at that moment.
- R5: The register select keeps its value across STOP and across transfers that carry no command byte.
- R6: A master NACK ends the read. SDA is released and no further `reg_rd` is issued in that transfer.
- R7: STOP at any point returns the slave to idle with SDA released and no strobe for the partial byte. A START or repeated START at any point restarts address reception.
- R8: SDA is only ever pulled low through `sda_oe`, and `sda_oe` changes only while the filtered SCL is low.
- R9: Pulses on SCL or SDA shorter than `FILT_CYC` system clocks have no effect on the transfer.
- R10: During and right after reset, `sda_oe`, `reg_wr` and `reg_rd` are 0 and the register select is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| sda_oe | output | 1 | High pulls SDA low |
| reg_sel | output | 2 | Register pointer from the last command byte |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write, valid with `reg_wr` |
| reg_rd | output | 1 | One-cycle strobe when a read byte is captured |
| reg_rdata | input | 8 | Value of the selected register, combinational from the core |

## Verification
The hardest situation to reach from the ports is a read of the input register where the port value changes between bytes. The check must show that each byte is captured at its own acknowledge edge and not at the start of the transfer. The bench's master task rewrites the modelled input value during the acknowledge bit, before the closing SCL fall, and expects the next byte to carry that new value. Filter rejection is reached by injecting short SDA dips while SCL is high and short SCL bumps while SCL is low, in the middle of a data byte. These would otherwise look like a START or an extra bit. The bench then checks that the byte still commits intact.

// File: rtl/sreg_i2c_pkg.sv
package sreg_i2c_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } bus_state_e;

  // Address frame: bits 7..1 address, bit 0 direction
  function automatic logic addr_hit(input logic [BYTE_W-1:0] frame,
                                    input logic [6:0] own);
    return frame[BYTE_W-1:1] == own;
  endfunction

  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur,
                                                 input logic bit_in);
    return {cur[BYTE_W-2:0], bit_in};
  endfunction

  // Pull-down enable needed to present a data bit on an open-drain line
  function automatic logic pull_for(input logic data_bit);
    return ~data_bit;
  endfunction

endpackage

// File: rtl/sreg_deglitch.sv
module sreg_deglitch #(
  parameter int W        = 2,
  parameter int FILT_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] clean
);
  localparam int CW = $clog2(FILT_CYC + 1);

  for (genvar g = 0; g < W; g++) begin : g_line
    logic          s1, s2, f;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1  <= 1'b1;
        s2  <= 1'b1;
        f   <= 1'b1;
        cnt <= '0;
      end else begin
        s1 <= raw[g];
        s2 <= s1;
        if (s2 == f) begin
          cnt <= '0;
        end else if (cnt == CW'(FILT_CYC - 1)) begin
          f   <= s2;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign clean[g] = f;
  end

endmodule

// File: rtl/sreg_cond_detect.sv
module sreg_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_c,
  input  logic sda_c,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_c;
      sda_d <= sda_c;
    end
  end

  assign scl_rise = scl_c & ~scl_d;
  assign scl_fall = ~scl_c & scl_d;
  assign start_ev = scl_c & scl_d & sda_d & ~sda_c;
  assign stop_ev  = scl_c & scl_d & ~sda_d & sda_c;

endmodule

// File: rtl/sreg_byte_engine.sv
module sreg_byte_engine
  import sreg_i2c_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'b1001001,
  parameter int         NREG     = 4,
  localparam int        PTR_W    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_c,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [PTR_W-1:0]  reg_sel,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              cmd_load
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] wbuf;
  logic [PTR_W-1:0]  ptr;
  logic              oe, rw, rack_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      wbuf     <= '0;
      ptr      <= '0;
      oe       <= 1'b0;
      rw       <= 1'b0;
      rack_ok  <= 1'b0;
      reg_wr   <= 1'b0;
      reg_rd   <= 1'b0;
      cmd_load <= 1'b0;
    end else begin
      reg_wr   <= 1'b0;
      reg_rd   <= 1'b0;
      cmd_load <= 1'b0;
      if (stop_ev) begin
        state <= ST_IDLE;
        oe    <= 1'b0;
      end else if (start_ev) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        oe      <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise && bit_cnt != FULL) begin
              shreg   <= shift_in(shreg, sda_c);
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == FULL) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit(shreg, SLV_ADDR)) begin
                  oe    <= 1'b1;
                  rw    <= shreg[0];
                  state <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_CMD) begin
                oe       <= 1'b1;
                ptr      <= shreg[PTR_W-1:0];
                cmd_load <= 1'b1;
                state    <= ST_CMD_ACK;
              end else begin
                oe    <= 1'b1;
                wbuf  <= shreg;
                state <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw) begin
                shreg  <= reg_rdata;
                reg_rd <= 1'b1;
                oe     <= pull_for(reg_rdata[BYTE_W-1]);
                state  <= ST_RDATA;
              end else begin
                oe    <= 1'b0;
                state <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK: begin
            if (scl_fall) begin
              oe    <= 1'b0;
              state <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              oe     <= 1'b0;
              reg_wr <= 1'b1;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == FULL) begin
                oe      <= 1'b0;
                bit_cnt <= '0;
                state   <= ST_RACK;
              end else begin
                shreg <= shift_in(shreg, 1'b0);
                oe    <= pull_for(shreg[BYTE_W-2]);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              rack_ok <= ~sda_c;
            end else if (scl_fall) begin
              if (rack_ok) begin
                shreg  <= reg_rdata;
                reg_rd <= 1'b1;
                oe     <= pull_for(reg_rdata[BYTE_W-1]);
                state  <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe;
  assign reg_sel   = ptr;
  assign reg_wdata = wbuf;

endmodule

// File: rtl/sreg_i2c_slave.sv
module sreg_i2c_slave
  import sreg_i2c_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'b1001001,
  parameter int         FILT_CYC = 4,
  parameter int         NREG     = 4,
  localparam int        PTR_W    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_sel,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [1:0] clean;
  logic       scl_c, sda_c;
  logic       scl_rise, scl_fall, start_ev, stop_ev;
  logic       cmd_load;

  sreg_deglitch #(.W(2), .FILT_CYC(FILT_CYC)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({scl_i, sda_i}),
    .clean (clean)
  );

  assign scl_c = clean[1];
  assign sda_c = clean[0];

  sreg_cond_detect u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_c    (scl_c),
    .sda_c    (sda_c),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  sreg_byte_engine #(.SLV_ADDR(SLV_ADDR), .NREG(NREG)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_c     (sda_c),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .cmd_load  (cmd_load)
  );

endmodule

// File: rtl/sreg_i2c_slave_chk.sv
module sreg_i2c_slave_chk #(
  parameter int PTR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_c,
  input logic             sda_oe,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [PTR_W-1:0] reg_sel,
  input logic             cmd_load,
  input logic             stop_ev
);
  // R8: pull-down enable moves only while filtered SCL is low
  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_c);

  // R3: a write strobe follows an acknowledge that the slave was driving
  p_wr_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> ($past(sda_oe) && !scl_c));

  // R4: read capture happens with SCL low, never together with a write
  p_rd_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> (!scl_c && !reg_wr));

  // R5: pointer only moves when a command byte is taken
  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_sel) |-> cmd_load);

  // R7: STOP leaves the line released
  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

endmodule

bind sreg_i2c_slave sreg_i2c_slave_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_c    (scl_c),
  .sda_oe   (sda_oe),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_sel  (reg_sel),
  .cmd_load (cmd_load),
  .stop_ev  (stop_ev)
);

// File: tb/sreg_i2c_slave_bench.sv
module sreg_i2c_slave_bench;
  localparam int HB   = 20;
  localparam int FILT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [1:0] reg_sel;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sda_line;

  logic [7:0] bank [1:3];
  logic [7:0] in_val = 8'h00;
  int         wr_cnt = 0, rd_cnt = 0;
  logic [7:0] last_wdata = 8'h00;
  logic [1:0] last_wsel = 2'd0;

  int  n_tests = 0, n_fail = 0;
  int  oe_bad = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = (reg_sel == 2'd0) ? in_val : bank[reg_sel];

  sreg_i2c_slave #(.FILT_CYC(FILT)) u_sreg_i2c_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata)
  );

  // Port-core model: holds written registers, counts strobes
  always @(posedge clk) begin
    if (!rst_n) begin
      bank[1] <= 8'hFF; bank[2] <= 8'h00; bank[3] <= 8'hFF;
    end else begin
      if (reg_wr) begin
        wr_cnt     <= wr_cnt + 1;
        last_wdata <= reg_wdata;
        last_wsel  <= reg_sel;
        if (reg_sel != 2'd0) bank[reg_sel] <= reg_wdata;
      end
      if (reg_rd) rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hb();
    repeat (HB) @(negedge clk);
  endtask

  // one SCL clock of a master-driven bit; optional short glitches
  task automatic bit_out(input logic b, input bit glitch);
    sda_m = b;
    if (glitch) begin
      repeat (HB/2) @(negedge clk);
      scl_m = 1'b1; repeat (FILT-2) @(negedge clk); scl_m = 1'b0;
      repeat (HB/2) @(negedge clk);
    end else hb();
    scl_m = 1'b1;
    if (glitch && b) begin
      repeat (HB/2) @(negedge clk);
      sda_m = 1'b0; repeat (FILT-2) @(negedge clk); sda_m = 1'b1;
      repeat (HB/2) @(negedge clk);
    end else hb();
    scl_m = 1'b0;
    hb();
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hb();
    scl_m = 1'b1; hb();
    sda_m = 1'b0; hb();
    scl_m = 1'b0; hb();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hb();
    scl_m = 1'b1; hb();
    sda_m = 1'b1; hb();
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit glitch, output bit acked);
    logic oe_a;
    for (int i = 7; i >= 0; i--) bit_out(b[i], glitch);
    sda_m = 1'b1; hb();
    scl_m = 1'b1;
    repeat (HB/2) @(negedge clk);
    acked = !sda_line;
    oe_a  = sda_oe;
    repeat (HB/2) @(negedge clk);
    if (sda_oe != oe_a) oe_bad++;
    scl_m = 1'b0; hb();
  endtask

  // upd: change the input-port value during the acknowledge bit
  task automatic rd_byte(input bit mack, input bit upd, input logic [7:0] nv,
                         output logic [7:0] b);
    logic oe_a;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hb();
      scl_m = 1'b1;
      oe_a = sda_oe;
      repeat (HB/2) @(negedge clk);
      b[i] = sda_line;
      repeat (HB/2) @(negedge clk);
      if (sda_oe != oe_a) oe_bad++;
      scl_m = 1'b0;
    end
    hb();
    if (upd) in_val = nv;
    sda_m = mack ? 1'b0 : 1'b1; hb();
    scl_m = 1'b1; hb();
    scl_m = 1'b0; hb();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] addr_byte(input bit rd);
    return {7'b1001001, rd};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit         ack;
    logic [7:0] rb;
    logic [7:0] exp_reg [1:3];
    int         w0, r0;

    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R10 reset outputs", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(reg_sel == 2'd0, "R10 reset pointer", reg_sel, 0);
    exp_reg[1] = 8'hFF; exp_reg[2] = 8'h00; exp_reg[3] = 8'hFF;

    // R1 R2 R3: write two bytes to register 1
    w0 = wr_cnt;
    i2c_start();
    wr_byte(addr_byte(0), 0, ack); chk(ack, "R1 address ack", ack, 1);
    wr_byte(8'h01, 0, ack);        chk(ack, "R2 command ack", ack, 1);
    chk(reg_sel == 2'd1, "R2 pointer load", reg_sel, 1);
    wr_byte(8'hA5, 0, ack);        chk(ack, "R3 data ack", ack, 1);
    chk(wr_cnt == w0 + 1 && last_wdata == 8'hA5, "R3 first commit", last_wdata, 8'hA5);
    wr_byte(8'h3C, 0, ack);
    chk(wr_cnt == w0 + 2 && last_wdata == 8'h3C && last_wsel == 2'd1,
        "R3 no auto-increment", {last_wsel, last_wdata}, {2'd1, 8'h3C});
    exp_reg[1] = 8'h3C;

    // R7 repeated START into a read; R4 two bytes; R6 NACK ends it
    r0 = rd_cnt;
    i2c_start();
    wr_byte(addr_byte(1), 0, ack); chk(ack, "R7 repeated start address ack", ack, 1);
    rd_byte(1, 0, 8'h00, rb);      chk(rb == 8'h3C, "R4 read byte 1", rb, 8'h3C);
    rd_byte(0, 0, 8'h00, rb);      chk(rb == 8'h3C, "R4 read byte 2", rb, 8'h3C);
    chk(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
    i2c_stop();
    chk(rd_cnt == r0 + 2, "R6 no capture after nack", rd_cnt - r0, 2);

    // R5 pointer retained across STOP
    i2c_start();
    wr_byte(addr_byte(1), 0, ack);
    rd_byte(0, 0, 8'h00, rb);      chk(rb == 8'h3C, "R5 pointer kept", rb, 8'h3C);
    i2c_stop();

    // R2 command above 3 uses low bits
    i2c_start();
    wr_byte(addr_byte(0), 0, ack);
    wr_byte(8'h06, 0, ack);        chk(ack, "R2 large command ack", ack, 1);
    chk(reg_sel == 2'd2, "R2 large command pointer", reg_sel, 2);
    wr_byte(8'h0F, 0, ack);
    i2c_stop();
    exp_reg[2] = 8'h0F;
    chk(last_wsel == 2'd2 && last_wdata == 8'h0F, "R2 large command write", last_wdata, 8'h0F);

    // R1 foreign address ignored
    w0 = wr_cnt;
    i2c_start();
    wr_byte(8'h94, 0, ack);        chk(!ack, "R1 foreign address no ack", ack, 0);
    wr_byte(8'h03, 0, ack);        chk(!ack, "R1 ignored byte no ack", ack, 0);
    wr_byte(8'hFF, 0, ack);
    i2c_stop();
    chk(wr_cnt == w0 && reg_sel == 2'd2, "R1 foreign transfer no effect", wr_cnt - w0, 0);

    // R4 input register refreshed per byte
    in_val = 8'h11;
    i2c_start();
    wr_byte(addr_byte(0), 0, ack);
    wr_byte(8'h00, 0, ack);
    i2c_start();
    wr_byte(addr_byte(1), 0, ack);
    rd_byte(1, 1, 8'h92, rb);      chk(rb == 8'h11, "R4 input byte 1", rb, 8'h11);
    rd_byte(1, 1, 8'h6E, rb);      chk(rb == 8'h92, "R4 input refreshed 2", rb, 8'h92);
    rd_byte(0, 1, 8'h00, rb);      chk(rb == 8'h6E, "R4 input refreshed 3", rb, 8'h6E);
    i2c_stop();

    // R7 STOP mid-byte aborts
    w0 = wr_cnt;
    i2c_start();
    wr_byte(addr_byte(0), 0, ack);
    wr_byte(8'h03, 0, ack);
    for (int i = 0; i < 4; i++) bit_out(1'b0, 0);
    i2c_stop();
    chk(wr_cnt == w0 && sda_oe == 1'b0, "R7 abort no commit", wr_cnt - w0, 0);
    i2c_start();
    wr_byte(addr_byte(0), 0, ack); chk(ack, "R7 recovers after abort", ack, 1);
    wr_byte(8'h03, 0, ack);
    wr_byte(8'h5A, 0, ack);
    i2c_stop();
    exp_reg[3] = 8'h5A;
    chk(last_wsel == 2'd3 && last_wdata == 8'h5A, "R7 write after abort", last_wdata, 8'h5A);

    // R9 short pulses on both lines within a data byte
    w0 = wr_cnt;
    i2c_start();
    wr_byte(addr_byte(0), 0, ack);
    wr_byte(8'h02, 0, ack);
    wr_byte(8'hB6, 1, ack);        chk(ack, "R9 glitched byte ack", ack, 1);
    i2c_stop();
    exp_reg[2] = 8'hB6;
    chk(wr_cnt == w0 + 1 && last_wdata == 8'hB6 && last_wsel == 2'd2,
        "R9 glitch rejected", last_wdata, 8'hB6);

    // R3 R5 random writes and read-backs
    for (int t = 0; t < 12; t++) begin
      logic [1:0] p;
      logic [7:0] d;
      int         nb;
      p  = 2'(1 + ($urandom % 3));
      nb = 1 + ($urandom % 3);
      i2c_start();
      wr_byte(addr_byte(0), 0, ack);
      wr_byte({6'($urandom), p}, 0, ack);
      for (int k = 0; k < nb; k++) begin
        d = 8'($urandom);
        wr_byte(d, 0, ack);
        exp_reg[p] = d;
      end
      i2c_stop();
      i2c_start();
      wr_byte(addr_byte(1), 0, ack);
      rd_byte(1, 0, 8'h00, rb);
      chk(rb == exp_reg[p], "R3 random read-back", rb, exp_reg[p]);
      rd_byte(0, 0, 8'h00, rb);
      chk(rb == exp_reg[p], "R5 random repeat byte", rb, exp_reg[p]);
      i2c_stop();
    end

    chk(oe_bad == 0, "R8 oe stable while SCL high", oe_bad, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule